// File: doc/BRIEF.md
# Dead-Band Output Guard

This block sits between a pulse-width comparator and the two gate-drive outputs of a half bridge. It takes a single raw request level, high meaning the upper switch should conduct and low meaning the lower switch should conduct. It turns that level into two outputs that are never high together. After either output turns off, both outputs stay low for a programmable number of clocks before the opposite output may turn on. The gap is set by a small code, and each step of the code is worth two cycles of the block clock. The block clock is the undivided input clock, so the gap does not depend on any prescaling applied to the counter that produces the request.

The block also carries the protective shutdown. A hardware disable input, or a software run bit that has been cleared, pulls both outputs low through a purely combinational path, with no clock edge needed. Once shut down, the outputs stay low after the cause has gone. They return only at a later start-of-period pulse, and only if, at that pulse, the run bit is set and the synchronised copy of the disable input has been clear.

Top module: `deadband_guard`

## Requirements
- R1: After the request toggles, the output that was on goes low on the next clock edge. The newly requested output rises only after exactly 2 × `dt_code` further clock edges, and both outputs are low during that gap.
- R2: With `dt_code` = 0 the outputs switch over on the same clock edge that samples the new request level, with no both-low cycle between them.
- R3: A request level held for 2 × `dt_code` clock edges or fewer never drives its output high. A level held for one clock edge more gives exactly one high cycle.
- R4: A request held constant (0 % or 100 % duty) keeps its output continuously high, with no gap inserted.
- R5: `out_a` and `out_b` are never high together, for any code or input sequence.
- R6: While `kill` = 1, both outputs are low immediately, without waiting for a clock edge.
- R7: While `run_en` = 0, both outputs are low immediately, without waiting for a clock edge.
- R8: After `kill` returns to 0 or `run_en` returns to 1, both outputs stay low until a clock edge where `cyc_start` = 1, `run_en` = 1, `kill` = 0 and the two-stage synchronised copy of `kill` is 0. In practice, `kill` must have been low for at least two earlier edges. From the edge after that one, outputs follow the request again.
- R9: While `rst_n` = 0, and after reset until the first qualifying `cyc_start`, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided block clock; clocks the dead-band counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Raw request: 1 selects `out_a`, 0 selects `out_b` |
| cyc_start | input | 1 | One-clock pulse marking the start of a PWM period |
| dt_code | input | DT_W (3) | Dead-band code; the gap is 2 × code clocks |
| run_en | input | 1 | Software run bit; 0 stops both outputs |
| kill | input | 1 | Hardware disable, active high |
| out_a | output | 1 | Upper-switch drive |
| out_b | output | 1 | Lower-switch drive |

## Verification
The hardest case to reach is re-arming close to the limit. A `cyc_start` that arrives while the synchronised copy of `kill` is still high must be refused, and the next one must be honoured. Random traffic almost never lines these up. The stimulus therefore places a start pulse on the very edge at which `kill` is released, and then a second start pulse a few cycles later. Request pulses exactly one clock either side of the dead-band length are driven the same way, so the swallow boundary is exercised as well.

// File: rtl/dg_pkg.sv
package dg_pkg;
   typedef enum logic {
      LEG_LOW  = 1'b0,
      LEG_HIGH = 1'b1
   } leg_e;

   function automatic int gap_max(input int code_w, input int unit);
      return ((1 << code_w) - 1) * unit;
   endfunction
endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("dg_sync: STAGES must be at least 2");
   end

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[0], d};
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dg_tracker.sv
module dg_tracker
   import dg_pkg::*;
#(
   parameter int DT_W    = 3,
   parameter int DT_UNIT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [DT_W-1:0] dt_code,
   output leg_e            side,
   output logic            settled
);
   localparam int GAP_MAX = gap_max(DT_W, DT_UNIT);
   localparam int CNT_W   = $clog2(GAP_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(GAP_MAX);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] need;
   leg_e             side_q;
   leg_e             side_in;

   assign side_in = req ? LEG_HIGH : LEG_LOW;
   assign need    = CNT_W'(dt_code) * CNT_W'(DT_UNIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         side_q <= LEG_LOW;
         cnt    <= CNT_TOP;
      end else if (side_in != side_q) begin
         side_q <= side_in;
         cnt    <= '0;
      end else if (cnt != CNT_TOP) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign side    = side_q;
   assign settled = (cnt >= need);
endmodule

// File: rtl/dg_enable.sv
module dg_enable #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic run_en,
   input  logic cyc_start,
   output logic en
);
   logic kill_s;
   logic en_q;
   logic clear;

   dg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (kill),
      .q    (kill_s)
   );

   assign clear = kill | kill_s | ~run_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (clear)     en_q <= 1'b0;
      else if (cyc_start) en_q <= 1'b1;
   end

   assign en = en_q;
endmodule

// File: rtl/deadband_guard.sv
module deadband_guard
   import dg_pkg::*;
#(
   parameter int DT_W        = 3,
   parameter int DT_UNIT     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            cyc_start,
   input  logic [DT_W-1:0] dt_code,
   input  logic            run_en,
   input  logic            kill,
   output logic            out_a,
   output logic            out_b
);
   localparam int LEGS = 2;

   if (DT_W < 1) begin : g_bad_w
      $error("deadband_guard: DT_W must be at least 1");
   end
   if (DT_UNIT < 1) begin : g_bad_unit
      $error("deadband_guard: DT_UNIT must be at least 1");
   end

   leg_e            side;
   logic            settled;
   logic            en;
   logic            pass;
   logic [LEGS-1:0] drive;

   dg_tracker #(.DT_W(DT_W), .DT_UNIT(DT_UNIT)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .dt_code(dt_code),
      .side   (side),
      .settled(settled)
   );

   dg_enable #(.SYNC_STAGES(SYNC_STAGES)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (kill),
      .run_en   (run_en),
      .cyc_start(cyc_start),
      .en       (en)
   );

   // Combinational force-low path: kill and run_en act without a clock edge.
   assign pass = en & settled & ~kill & run_en;

   for (genvar g = 0; g < LEGS; g++) begin : g_leg
      localparam leg_e MY_SIDE = (g == 0) ? LEG_HIGH : LEG_LOW;
      assign drive[g] = pass & (side == MY_SIDE);
   end

   assign out_a = drive[0];
   assign out_b = drive[1];
endmodule

// File: rtl/dg_chk.sv
module dg_chk #(
   parameter int DT_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req,
   input logic            cyc_start,
   input logic [DT_W-1:0] dt_code,
   input logic            run_en,
   input logic            kill,
   input logic            out_a,
   input logic            out_b
);
   AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_a && out_b)); // R5

   AST_KILL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> (!out_a && !out_b)); // R6

   AST_STOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> (!out_a && !out_b)); // R7

   AST_HOLD_AFTER_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(kill) |-> (!out_a && !out_b)); // R8

   AST_GAP_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(out_b) && dt_code != '0 && $stable(dt_code)) |=> !out_a); // R1

   AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_a) |-> $past(req)); // R3
endmodule

bind deadband_guard dg_chk #(.DT_W(DT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .cyc_start(cyc_start),
   .dt_code  (dt_code),
   .run_en   (run_en),
   .kill     (kill),
   .out_a    (out_a),
   .out_b    (out_b)
);

// File: tb/sim_deadband_guard.sv
module sim_deadband_guard;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       cyc_start = 1'b0;
   logic [2:0] dt_code = 3'd0;
   logic       run_en = 1'b0;
   logic       kill = 1'b0;
   logic       out_a, out_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   deadband_guard u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .cyc_start(cyc_start),
      .dt_code(dt_code), .run_en(run_en), .kill(kill),
      .out_a(out_a), .out_b(out_b)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Bench model built from the requirements
   logic m_lvl, m_en, m_s1, m_s2;
   int   m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lvl <= 1'b0; m_cnt <= 14; m_en <= 1'b0; m_s1 <= 1'b1; m_s2 <= 1'b1;
      end else begin
         m_s1 <= kill;
         m_s2 <= m_s1;
         if (kill || m_s2 || !run_en) m_en <= 1'b0;
         else if (cyc_start)          m_en <= 1'b1;
         if (req != m_lvl) begin
            m_lvl <= req; m_cnt <= 0;
         end else if (m_cnt < 14) begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   function automatic bit exp_out(input bit leg_a);
      bit on = m_en && !kill && run_en && (m_cnt >= 2 * int'(dt_code));
      return on && (leg_a ? m_lvl : !m_lvl);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_pulse();
      cyc_start = 1'b1; step(); cyc_start = 1'b0;
   endtask

   // Toggle request, count both-low samples until the new leg rises
   task automatic gap_measure(input bit to_a, input int exp_gap, input string tag);
      int n = 0;
      int both = 0;
      req = to_a;
      step();
      while (!(to_a ? out_a : out_b) && n < 40) begin
         if (out_a || out_b) both++;
         n++;
         step();
      end
      chk(n == exp_gap && both == 0, tag, n, exp_gap);
   endtask

   task automatic pulse_count(input int len, input int exp_hi, input string tag);
      int hi = 0;
      req = 1'b1;
      repeat (len) begin step(); hi += int'(out_a); end
      req = 1'b0;
      repeat (20) begin step(); hi += int'(out_a); end
      chk(hi == exp_hi, tag, hi, exp_hi);
   endtask

   initial begin
      int hi;
      int hold;
      void'($urandom(32'h5eed_0101));

      // R9: reset state
      step(3);
      chk(!out_a && !out_b, "R9 outputs low in reset", {out_a, out_b}, 0);
      rst_n = 1'b1;
      run_en = 1'b1; dt_code = 3'd3; req = 1'b1;
      step(4);
      chk(!out_a && !out_b, "R9 low before first start", {out_a, out_b}, 0);
      start_pulse();
      step(10);

      // R4: steady 100 %
      hi = 0;
      repeat (100) begin step(); hi += int'(out_a && !out_b); end
      chk(hi == 100, "R4 steady high without gap", hi, 100);

      // R1: gap of 2*code clocks in both directions
      gap_measure(1'b0, 6, "R1 gap code 3 a->b");
      step(20);
      dt_code = 3'd7;
      gap_measure(1'b1, 14, "R1 gap code 7 b->a");
      step(20);

      // R2: code 0 gives no gap
      dt_code = 3'd0;
      gap_measure(1'b0, 0, "R2 no gap a->b");
      gap_measure(1'b1, 0, "R2 no gap b->a");

      // R3: swallow boundary, code 3 -> 6 clocks
      dt_code = 3'd3; req = 1'b0; step(20);
      pulse_count(6, 0, "R3 pulse of gap length swallowed");
      pulse_count(7, 1, "R3 pulse one over gap gives one cycle");

      // R6: kill forces low without an edge
      req = 1'b1; step(20);
      chk(out_a, "R6 precondition out_a high", out_a, 1);
      #2 kill = 1'b1;
      #1 chk(!out_a && !out_b, "R6 kill immediate", {out_a, out_b}, 0);
      step(3);
      kill = 1'b0;
      // R8: start on the release edge is refused
      start_pulse();
      chk(!out_a && !out_b, "R8 start on release edge refused", {out_a, out_b}, 0);
      hi = 0;
      repeat (5) begin step(); hi += int'(out_a || out_b); end
      chk(hi == 0, "R8 stay low until next start", hi, 0);
      start_pulse();
      chk(out_a && !out_b, "R8 recovery at next start", {out_a, out_b}, 2);

      // R7: stop bit forces low without an edge, then holds
      step(5);
      #2 run_en = 1'b0;
      #1 chk(!out_a && !out_b, "R7 stop immediate", {out_a, out_b}, 0);
      step(2);
      run_en = 1'b1;
      hi = 0;
      repeat (4) begin step(); hi += int'(out_a || out_b); end
      chk(hi == 0, "R8 stop release waits for start", hi, 0);
      start_pulse();
      chk(out_a && !out_b, "R8 recovery after stop", {out_a, out_b}, 2);

      // Random phase against the bench model
      hold = 1;
      for (int cyc = 0; cyc < 6000; cyc++) begin
         chk(!(out_a && out_b), "R5 never both high", {out_a, out_b}, 0);
         chk(out_a == exp_out(1'b1) && out_b == exp_out(1'b0), "R1 model match",
             {out_a, out_b}, {exp_out(1'b1), exp_out(1'b0)});
         hold--;
         if (hold <= 0) begin
            req  = ~req;
            hold = int'($urandom_range(1, 20));
         end
         if (cyc % 500 == 0) dt_code = 3'($urandom_range(0, 7));
         cyc_start = (cyc % 64 == 0);
         if (kill) kill = ($urandom_range(0, 3) != 0);
         else      kill = ($urandom_range(0, 199) == 0);
         if (!run_en) run_en = ($urandom_range(0, 4) == 0);
         else         run_en = ($urandom_range(0, 299) != 0);
         step();
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule